// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Holding Register

This block turns bytes written by a host into asynchronous serial frames. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or more high stop bits. A one-byte holding register accepts the host's write. A shift register drains it onto the line. An external 16x baud strobe (`tickEn`) paces all timing, so every bit lasts sixteen strobes.

The line format comes from a set of configuration inputs: word length code, stop select, parity enable, parity type, forced parity and break. These are captured when a byte moves into the shift register, so the frame already on the line is not affected by later changes. A loopback input keeps the external line at mark and sends the frame to a separate internal output instead. Two flags report the state of the transmitter: holding register empty, and transmitter fully idle.

Top module: `async_tx`

## Requirements
- R1: After reset `txOut` is 1, `holdEmpty` is 1 and `txIdle` is 1.
- R2: A frame begins with a start bit at 0, then the data bits go out least significant bit first. Each bit lasts OVS (16) strobes of `tickEn`, and only strobes advance the timing.
- R3: `lenSel` selects the word length: 00 = 5 bits, 01 = 6 bits, 10 = 7 bits, 11 = 8 bits. Unused upper bits of `wrData` are not sent.
- R4: With `parEn`=1 and `parForce`=0, one parity bit follows the data. With `parType`=0 the data ones plus the parity bit add up to an odd count. With `parType`=1 they add up to an even count.
- R5: With `parEn`=1 and `parForce`=1, the parity bit is 1 when `parType`=0 and 0 when `parType`=1.
- R6: With `stopSel`=0 the stop period is 16 strobes. With `stopSel`=1 it is 24 strobes for 5-bit words and 32 strobes for 6-, 7- and 8-bit words. If a byte is waiting, its start bit begins on the strobe that ends the stop period. The spacing between the start edges of frames sent back to back is therefore exactly 16·(1+bits+parity) + stop strobes.
- R7: `holdEmpty` goes to 0 in the cycle after a write. It returns to 1 in the cycle after the byte moves into the shift register.
- R8: `txIdle` is 1 only when neither the holding register nor the shift register holds a character.
- R9: While `brkEn` is 1, `txOut` is 0. When `brkEn` is cleared on an idle transmitter, `txOut` returns to 1.
- R10: While `loopEn` is 1, `txOut` stays 1 and the complete frame appears on `loopOut`.
- R11: A write while the holding register is full replaces the pending byte. Only the last byte written is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | 16x baud strobe, one cycle wide |
| wrEn | input | 1 | Host write strobe |
| wrData | input | 8 | Byte to send |
| lenSel | input | 2 | Word length code |
| stopSel | input | 1 | Extended stop period select |
| parEn | input | 1 | Parity bit enable |
| parType | input | 1 | 0 odd, 1 even (when forced: 0 gives 1, 1 gives 0) |
| parForce | input | 1 | Fixed parity value enable |
| brkEn | input | 1 | Hold the line at space |
| loopEn | input | 1 | Route the frame to `loopOut` and hold `txOut` at mark |
| txOut | output | 1 | Serial line |
| loopOut | output | 1 | Internal loopback serial line |
| holdEmpty | output | 1 | Holding register empty |
| txIdle | output | 1 | Holding and shift registers both empty |

## Verification
The hardest case to reach from the ports is a hand-over from one frame to the next at the exact strobe that ends the stop period. The 24-strobe half-stop case for 5-bit words is especially hard to hit. The stimulus writes the second byte as soon as `holdEmpty` rises during the first frame, so the next byte is always waiting when the stop period ends. The bench then compares the start-edge spacing with the exact formula. The overwrite case is reached by writing twice while the first frame is still shifting.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } txState_e;

  typedef enum logic [1:0] {
    LINE_MARK,
    LINE_SPACE,
    LINE_DATA,
    LINE_PAR
  } lineSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     loadShift;
    logic     shiftNext;
    lineSel_e lineSel;
  } txStrobe_t;

endpackage

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl
  import async_tx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      wrEn,
  input  logic [1:0] lenSel,
  input  logic      stopSel,
  input  logic      parEn,
  output txStrobe_t strobe,
  output logic      holdFull,
  output logic      shiftBusy
);

  localparam int CNT_W = $clog2(2 * OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS + OVS / 2 - 1);
  localparam logic [CNT_W-1:0] DBL_LAST  = CNT_W'(2 * OVS - 1);

  txState_e         state, stateNxt;
  logic [CNT_W-1:0] tickCnt, tickCntNxt;
  logic [IDX_W-1:0] bitIdx, bitIdxNxt;
  logic [IDX_W-1:0] lastIdx;
  logic [CNT_W-1:0] stopLast;
  logic             parLat;
  logic [CNT_W-1:0] curLast;
  logic             bitDone;
  logic             startFrame;
  logic             shiftNext;

  assign curLast    = (state == ST_STOP) ? stopLast : BIT_LAST;
  assign bitDone    = tickEn && (tickCnt == curLast);
  assign startFrame = tickEn && holdFull &&
                      ((state == ST_IDLE) || ((state == ST_STOP) && bitDone));

  always_comb begin
    stateNxt   = state;
    tickCntNxt = tickCnt;
    bitIdxNxt  = bitIdx;
    shiftNext  = 1'b0;
    if (startFrame) begin
      stateNxt   = ST_START;
      tickCntNxt = '0;
    end else if (tickEn && (state != ST_IDLE)) begin
      if (!bitDone) begin
        tickCntNxt = tickCnt + CNT_W'(1);
      end else begin
        tickCntNxt = '0;
        case (state)
          ST_START: begin
            stateNxt  = ST_DATA;
            bitIdxNxt = '0;
          end
          ST_DATA: begin
            shiftNext = 1'b1;
            if (bitIdx == lastIdx) stateNxt = parLat ? ST_PAR : ST_STOP;
            else                   bitIdxNxt = bitIdx + IDX_W'(1);
          end
          ST_PAR:  stateNxt = ST_STOP;
          default: stateNxt = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tickCnt  <= '0;
      bitIdx   <= '0;
      lastIdx  <= '0;
      stopLast <= BIT_LAST;
      parLat   <= 1'b0;
      holdFull <= 1'b0;
    end else begin
      state   <= stateNxt;
      tickCnt <= tickCntNxt;
      bitIdx  <= bitIdxNxt;
      if (startFrame) begin
        lastIdx  <= IDX_W'(DATA_W - 4) + IDX_W'(lenSel);
        parLat   <= parEn;
        stopLast <= !stopSel ? BIT_LAST : ((lenSel == 2'b00) ? HALF_LAST : DBL_LAST);
      end
      if (wrEn)            holdFull <= 1'b1;
      else if (startFrame) holdFull <= 1'b0;
    end
  end

  always_comb begin
    strobe.loadShift = startFrame;
    strobe.shiftNext = shiftNext;
    case (state)
      ST_START: strobe.lineSel = LINE_SPACE;
      ST_DATA:  strobe.lineSel = LINE_DATA;
      ST_PAR:   strobe.lineSel = LINE_PAR;
      default:  strobe.lineSel = LINE_MARK;
    endcase
  end

  assign shiftBusy = (state != ST_IDLE);

  assert_hold_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> holdFull);

  assert_load_empties_R7: assert property (@(posedge clk) disable iff (!rstN)
    (startFrame && !wrEn) |=> !holdFull);

  assert_tick_pacing_R2: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> ($stable(tickCnt) && $stable(state)));

  assert_chain_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && tickEn && tickCnt == stopLast && holdFull) |=> (state == ST_START));

endmodule

// File: rtl/async_tx_dp.sv
module async_tx_dp
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        lenSel,
  input  logic              parType,
  input  logic              parForce,
  input  txStrobe_t         strobe,
  output logic              serBit
);

  logic [DATA_W-1:0] holdData;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] lenMask;
  logic              onesOdd;
  logic              parCalc;
  logic              parBit;

  assign lenMask = {DATA_W{1'b1}} >> (2'd3 - lenSel);
  assign onesOdd = ^(holdData & lenMask);

  always_comb begin
    if (parForce)     parCalc = ~parType;
    else if (parType) parCalc = onesOdd;
    else              parCalc = ~onesOdd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData <= '0;
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (wrEn) holdData <= wrData;
      if (strobe.loadShift) begin
        shiftReg <= holdData;
        parBit   <= parCalc;
      end else if (strobe.shiftNext) begin
        shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
      end
    end
  end

  always_comb begin
    case (strobe.lineSel)
      LINE_SPACE: serBit = 1'b0;
      LINE_DATA:  serBit = shiftReg[0];
      LINE_PAR:   serBit = parBit;
      default:    serBit = 1'b1;
    endcase
  end

  assert_shift_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadShift && !strobe.shiftNext) |=> $stable(shiftReg));

endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        lenSel,
  input  logic              stopSel,
  input  logic              parEn,
  input  logic              parType,
  input  logic              parForce,
  input  logic              brkEn,
  input  logic              loopEn,
  output logic              txOut,
  output logic              loopOut,
  output logic              holdEmpty,
  output logic              txIdle
);

  txStrobe_t strobe;
  logic      holdFull;
  logic      shiftBusy;
  logic      serBit;

  async_tx_ctrl #(.OVS(OVS), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .wrEn      (wrEn),
    .lenSel    (lenSel),
    .stopSel   (stopSel),
    .parEn     (parEn),
    .strobe    (strobe),
    .holdFull  (holdFull),
    .shiftBusy (shiftBusy)
  );

  async_tx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .lenSel   (lenSel),
    .parType  (parType),
    .parForce (parForce),
    .strobe   (strobe),
    .serBit   (serBit)
  );

  assign loopOut   = serBit & ~brkEn;
  assign txOut     = loopEn | (serBit & ~brkEn);
  assign holdEmpty = ~holdFull;
  assign txIdle    = ~holdFull & ~shiftBusy;

  assert_idle_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    txIdle |-> holdEmpty);

endmodule

// File: tb/async_tx_tb.sv
module async_tx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_PER_BIT = 32;  // 16 strobes, one every 2 clocks

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [1:0] lenSel = '0;
  logic       stopSel = 1'b0, parEn = 1'b0, parType = 1'b0, parForce = 1'b0;
  logic       brkEn = 1'b0, loopEn = 1'b0;
  logic       txOut, loopOut, holdEmpty, txIdle;

  int nChecks = 0;
  int nFail = 0;
  longint cyc = 0;
  bit done = 1'b0;

  async_tx u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrData(wrData),
    .lenSel(lenSel), .stopSel(stopSel), .parEn(parEn), .parType(parType),
    .parForce(parForce), .brkEn(brkEn), .loopEn(loopEn), .txOut(txOut),
    .loopOut(loopOut), .holdEmpty(holdEmpty), .txIdle(txIdle)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      @(negedge clk);
      tickEn = ~tickEn;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] maskData(input logic [7:0] d, input int n);
    return d & 8'((1 << n) - 1);
  endfunction

  function automatic logic expParity(input logic [7:0] d, input int n, input bit pt, input bit pf);
    int ones = $countones(maskData(d, n));
    if (pf) return !pt;
    return pt ? logic'(ones % 2) : logic'((ones + 1) % 2);
  endfunction

  function automatic int stopTicks(input int n, input bit s);
    if (!s) return 16;
    return (n == 5) ? 24 : 32;
  endfunction

  function automatic logic lineOf(input bit useLoop);
    return useLoop ? loopOut : txOut;
  endfunction

  task automatic rxFrame(input bit useLoop, input int n, input bit hasPar,
                         output logic [7:0] d, output logic p, output logic startBit,
                         output logic stopBit, output longint fallCyc);
    logic prev = lineOf(useLoop);
    int guard = 0;
    d = '0; p = 1'b0; startBit = 1'b1; stopBit = 1'b0; fallCyc = -1;
    forever begin
      @(negedge clk);
      guard++;
      if (prev && !lineOf(useLoop)) break;
      prev = lineOf(useLoop);
      if (guard > 4000) return;
    end
    fallCyc = cyc;
    repeat (CLK_PER_BIT / 2) @(negedge clk);
    startBit = lineOf(useLoop);
    for (int i = 0; i < n; i++) begin
      repeat (CLK_PER_BIT) @(negedge clk);
      d[i] = lineOf(useLoop);
    end
    if (hasPar) begin
      repeat (CLK_PER_BIT) @(negedge clk);
      p = lineOf(useLoop);
    end
    repeat (CLK_PER_BIT) @(negedge clk);
    stopBit = lineOf(useLoop);
  endtask

  task automatic wrByte(input logic [7:0] b);
    wrEn = 1'b1;
    wrData = b;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitIdle();
    int g = 0;
    while (!txIdle && g < 4000) begin @(negedge clk); g++; end
  endtask

  // Two frames back to back; checks data, parity, framing and start-to-start spacing
  task automatic runPair(input logic [1:0] ls, input bit ss, input bit pe, input bit pt,
                         input bit pf, input logic [7:0] a, input logic [7:0] b,
                         input bit overwrite, input bit useLoop);
    int n = 5 + int'(ls);
    logic [7:0] d1, d2;
    logic p1, p2, s1, s2, t1, t2;
    longint f1, f2;
    logic [7:0] second = b;
    longint expGap = 2 * (16 * (1 + n + int'(pe)) + stopTicks(n, ss));
    int loopHighBad = 0;
    lenSel = ls; stopSel = ss; parEn = pe; parType = pt; parForce = pf; loopEn = useLoop;
    @(negedge clk);
    fork
      begin
        rxFrame(useLoop, n, pe, d1, p1, t1, s1, f1);
        rxFrame(useLoop, n, pe, d2, p2, t2, s2, f2);
      end
      begin
        wrByte(a);
        check(holdEmpty == 1'b0, "R7 holdEmpty after write", holdEmpty, 0);
        check(txIdle == 1'b0, "R8 txIdle with byte pending", txIdle, 0);
        while (!holdEmpty) @(negedge clk);
        check(txIdle == 1'b0, "R8 txIdle while shifting", txIdle, 0);
        if (overwrite) begin
          wrByte(b ^ 8'h5A);
          wrByte(b);
        end else begin
          wrByte(b);
        end
      end
      begin
        if (useLoop) begin
          for (int i = 0; i < 2 * 12 * CLK_PER_BIT; i++) begin
            @(negedge clk);
            if (!txOut) loopHighBad++;
          end
        end
      end
    join
    check(t1 == 1'b0 && t2 == 1'b0, "R2 start bit low", {t1, t2}, 0);
    check(d1 == maskData(a, n), "R2 R3 first frame data", d1, maskData(a, n));
    check(d2 == maskData(second, n), overwrite ? "R11 overwritten byte sent" : "R3 second frame data",
          d2, maskData(second, n));
    if (pe) begin
      check(p1 == expParity(a, n, pt, pf), pf ? "R5 forced parity" : "R4 parity", p1,
            expParity(a, n, pt, pf));
      check(p2 == expParity(second, n, pt, pf), pf ? "R5 forced parity 2" : "R4 parity 2", p2,
            expParity(second, n, pt, pf));
    end
    check(s1 == 1'b1 && s2 == 1'b1, "R6 stop bit high", {s1, s2}, 3);
    check(f2 - f1 == expGap, "R6 frame spacing", f2 - f1, expGap);
    if (useLoop) check(loopHighBad == 0, "R10 txOut held high in loopback", loopHighBad, 0);
    waitIdle();
    repeat (3 * CLK_PER_BIT) @(negedge clk);
    check(txIdle == 1'b1 && holdEmpty == 1'b1, "R8 R11 idle after pair, no extra frame",
          {txIdle, holdEmpty}, 3);
    check(txOut == 1'b1, "R1 line high when idle", txOut, 1);
    loopEn = 1'b0;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    check(txOut == 1'b1, "R1 line high in reset", txOut, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(txOut == 1'b1, "R1 txOut after reset", txOut, 1);
    check(holdEmpty == 1'b1, "R1 holdEmpty after reset", holdEmpty, 1);
    check(txIdle == 1'b1, "R1 txIdle after reset", txIdle, 1);

    // Directed: every word length, parity kinds, stop variants
    runPair(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, 1'b0, 1'b0);
    runPair(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h0A, 1'b0, 1'b0); // R6 1.5 stop
    runPair(2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 8'h2B, 8'h00, 1'b0, 1'b0); // R4 odd
    runPair(2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 8'h7F, 8'h41, 1'b0, 1'b0); // R4 even
    runPair(2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h81, 1'b0, 1'b0); // R5 mark
    runPair(2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h18, 1'b0, 1'b0); // R5 space
    runPair(2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 8'hC3, 8'h96, 1'b1, 1'b0); // R11
    runPair(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'h55, 8'h6E, 1'b0, 1'b1); // R10

    // R9 break on an idle line
    brkEn = 1'b1;
    @(negedge clk);
    check(txOut == 1'b0, "R9 break drives low", txOut, 0);
    repeat (40) @(negedge clk);
    check(txOut == 1'b0, "R9 break held low", txOut, 0);
    brkEn = 1'b0;
    @(negedge clk);
    check(txOut == 1'b1, "R9 line released", txOut, 1);

    // Random configurations and data
    for (int k = 0; k < 12; k++) begin
      runPair(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              8'($urandom), 8'($urandom), 1'($urandom), 1'b0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule